// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

A small, fully associative translation buffer that maps virtual page numbers to physical page numbers. Each slot stores a page tag, a physical page number, an address-space number, a global flag, a valid bit, per-privilege-mode read and write enable masks, and two trap-on-access flags (one for reads, one for writes). A lookup presents a page number and the current address-space number. The block answers in the same cycle with a hit flag, the slot index and that slot's fields.

A three-slot recent-hit store is consulted ahead of the full array. A hit that comes only from the full array is copied into this store. New mappings are written at a rotating victim pointer. Three invalidation flavours are provided: clear everything, clear every non-global slot, and clear the slots that match a given page and address space. Page-table walking and trap generation are left to the surrounding logic.

Top module: `asn_tlb`

## Requirements
- R1: After reset no lookup hits and `recent_hit_o` is 0.
- R2: A slot matches a lookup when it is valid, its tag equals `lk_vpn_i`, and either its global flag is set or its stored address-space number equals `lk_asn_i`. `hit_o` is 1 exactly when some slot matches.
- R3: When the recent store does not hit, the lowest-indexed matching slot is reported. `hit_idx_o` and all `hit_*` field outputs carry that slot's contents. On a miss every field output is 0.
- R4: The recent slots are checked in the order 0, 1, 2, before the array, and `recent_hit_o` shows such a hit. If a cycle has `lk_req_i`=1, a hit from the array alone, and no operation, that slot index enters recent slot 0. Slots 0 and 1 move down to 1 and 2, and slot 2 is dropped.
- R5: Any insert or invalidation empties the recent store at the same clock edge.
- R6: Insert writes the mapping into the slot at the victim pointer and marks it valid, overwriting whatever was there. It then advances the pointer, which wraps from `N_ENTRIES-1` to 0. The pointer starts at 0.
- R7: Invalidate-all clears every slot and returns the victim pointer to 0.
- R8: Invalidate-process clears every non-global slot and keeps the global ones.
- R9: Invalidate-by-address clears every slot that would match a lookup of `inv_vpn_i`/`inv_asn_i` under the rule of R2.
- R10: When several operations are requested in one cycle, exactly one takes effect. The priority, highest first, is insert, invalidate-all, invalidate-process, invalidate-by-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup is a real access (allows promotion into the recent store) |
| lk_vpn_i | input | VPN_W | Lookup page number |
| lk_asn_i | input | ASN_W | Current address-space number |
| ins_i | input | 1 | Insert request |
| ins_vpn_i | input | VPN_W | Page number of the new mapping |
| ins_ppn_i | input | PPN_W | Physical page of the new mapping |
| ins_asn_i | input | ASN_W | Address space of the new mapping |
| ins_glob_i | input | 1 | New mapping is global |
| ins_rd_en_i | input | N_MODES | Read enable per privilege mode |
| ins_wr_en_i | input | N_MODES | Write enable per privilege mode |
| ins_frd_i | input | 1 | Trap on read |
| ins_fwr_i | input | 1 | Trap on write |
| inv_all_i | input | 1 | Invalidate all slots |
| inv_proc_i | input | 1 | Invalidate non-global slots |
| inv_addr_i | input | 1 | Invalidate by page and address space |
| inv_vpn_i | input | VPN_W | Page number for invalidate-by-address |
| inv_asn_i | input | ASN_W | Address space for invalidate-by-address |
| hit_o | output | 1 | Lookup hit |
| recent_hit_o | output | 1 | Hit came from the recent store |
| hit_idx_o | output | IDX_W | Index of the reported slot |
| hit_ppn_o | output | PPN_W | Physical page of the reported slot |
| hit_asn_o | output | ASN_W | Stored address space of the reported slot |
| hit_glob_o | output | 1 | Global flag of the reported slot |
| hit_rd_en_o | output | N_MODES | Read enables of the reported slot |
| hit_wr_en_o | output | N_MODES | Write enables of the reported slot |
| hit_frd_o | output | 1 | Trap-on-read of the reported slot |
| hit_fwr_o | output | 1 | Trap-on-write of the reported slot |

## Verification
The bench loads two slots with the same page, where the lower slot is global and the higher one carries a specific address space. A design that favoured the higher index, or ignored the global flag, would report the wrong slot. The bench fills every slot and then inserts once more. A pointer that fails to wrap would write past the last slot and leave slot 0 stale. It promotes four different pages in a row, so the oldest must fall out of the recent store, and it issues an insert after a promotion. A recent store that is not cleared would keep serving a slot whose contents have since changed. Insert and invalidate-all are raised together so that a wrong priority shows up as a lost mapping. Invalidate-process and invalidate-by-address are applied to a mix of global and private slots. A design that dropped a global slot, or missed a global match on an address flush, would disagree with the model.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_INSERT,
    OP_FLUSH_ALL,
    OP_FLUSH_PROC,
    OP_FLUSH_ADDR
  } tlb_op_e;

  // fixed priority: insert, all, process, address
  function automatic tlb_op_e decode_op(input logic ins, input logic all,
                                        input logic proc, input logic addr);
    if (ins)       return OP_INSERT;
    else if (all)  return OP_FLUSH_ALL;
    else if (proc) return OP_FLUSH_PROC;
    else if (addr) return OP_FLUSH_ADDR;
    else           return OP_IDLE;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 19,
  parameter int ASN_W     = 8
) (
  input  logic [N_ENTRIES-1:0]            vld_i,
  input  logic [N_ENTRIES-1:0]            glob_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [N_ENTRIES-1:0][ASN_W-1:0] asn_i,
  input  logic [VPN_W-1:0]                vpn_i,
  input  logic [ASN_W-1:0]                cur_asn_i,
  output logic [N_ENTRIES-1:0]            match_o
);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign match_o[i] = vld_i[i] && (tag_i[i] == vpn_i) &&
                        (glob_i[i] || (asn_i[i] == cur_asn_i));
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

endmodule

// File: rtl/tlb_recent.sv
module tlb_recent #(
  parameter int N_SLOTS = 3,
  parameter int IDX_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          push_i,
  input  logic [IDX_W-1:0]              push_idx_i,
  output logic [N_SLOTS-1:0]            vld_o,
  output logic [N_SLOTS-1:0][IDX_W-1:0] idx_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= '0;
      idx_o <= '0;
    end else if (clr_i) begin
      vld_o <= '0;
    end else if (push_i) begin
      for (int s = N_SLOTS - 1; s > 0; s--) begin
        vld_o[s] <= vld_o[s-1];
        idx_o[s] <= idx_o[s-1];
      end
      vld_o[0] <= 1'b1;
      idx_o[0] <= push_idx_i;
    end
  end

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 19,
  parameter int PPN_W     = 21,
  parameter int ASN_W     = 8,
  parameter int N_MODES   = 4,
  parameter int N_RECENT  = 3,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_req_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  input  logic [ASN_W-1:0]   lk_asn_i,
  input  logic               ins_i,
  input  logic [VPN_W-1:0]   ins_vpn_i,
  input  logic [PPN_W-1:0]   ins_ppn_i,
  input  logic [ASN_W-1:0]   ins_asn_i,
  input  logic               ins_glob_i,
  input  logic [N_MODES-1:0] ins_rd_en_i,
  input  logic [N_MODES-1:0] ins_wr_en_i,
  input  logic               ins_frd_i,
  input  logic               ins_fwr_i,
  input  logic               inv_all_i,
  input  logic               inv_proc_i,
  input  logic               inv_addr_i,
  input  logic [VPN_W-1:0]   inv_vpn_i,
  input  logic [ASN_W-1:0]   inv_asn_i,
  output logic               hit_o,
  output logic               recent_hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PPN_W-1:0]   hit_ppn_o,
  output logic [ASN_W-1:0]   hit_asn_o,
  output logic               hit_glob_o,
  output logic [N_MODES-1:0] hit_rd_en_o,
  output logic [N_MODES-1:0] hit_wr_en_o,
  output logic               hit_frd_o,
  output logic               hit_fwr_o
);

  logic [N_ENTRIES-1:0]              vld_q, glob_q, frd_q, fwr_q;
  logic [N_ENTRIES-1:0][VPN_W-1:0]   tag_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]   ppn_q;
  logic [N_ENTRIES-1:0][ASN_W-1:0]   asn_q;
  logic [N_ENTRIES-1:0][N_MODES-1:0] rd_q, wr_q;

  logic [N_ENTRIES-1:0]            lk_vec, inv_vec;
  logic [IDX_W-1:0]                victim_q;
  logic [N_RECENT-1:0]             rc_vld;
  logic [N_RECENT-1:0][IDX_W-1:0]  rc_idx;
  logic                            rc_hit, main_hit;
  logic [IDX_W-1:0]                rc_sel, main_sel, sel;
  tlb_op_e                         op;

  assign op = decode_op(ins_i, inv_all_i, inv_proc_i, inv_addr_i);

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .vld_i(vld_q), .glob_i(glob_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(lk_vpn_i), .cur_asn_i(lk_asn_i), .match_o(lk_vec)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_inv_match (
    .vld_i(vld_q), .glob_i(glob_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(inv_vpn_i), .cur_asn_i(inv_asn_i), .match_o(inv_vec)
  );

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i, .rst_ni,
    .adv_i(op == OP_INSERT),
    .clr_i(op == OP_FLUSH_ALL),
    .ptr_o(victim_q)
  );

  tlb_recent #(.N_SLOTS(N_RECENT), .IDX_W(IDX_W)) u_recent (
    .clk_i, .rst_ni,
    .clr_i(op != OP_IDLE),
    .push_i(lk_req_i && main_hit && !rc_hit),
    .push_idx_i(main_sel),
    .vld_o(rc_vld),
    .idx_o(rc_idx)
  );

  // recent slots first, slot 0 highest priority
  always_comb begin
    rc_hit = 1'b0;
    rc_sel = '0;
    for (int s = N_RECENT - 1; s >= 0; s--) begin
      if (rc_vld[s] && lk_vec[rc_idx[s]]) begin
        rc_hit = 1'b1;
        rc_sel = rc_idx[s];
      end
    end
  end

  // lowest index wins in the full array
  always_comb begin
    main_sel = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (lk_vec[i]) main_sel = IDX_W'(i);
    end
  end

  assign main_hit = |lk_vec;
  assign sel      = rc_hit ? rc_sel : main_sel;

  always_comb begin
    hit_o        = main_hit;
    recent_hit_o = rc_hit;
    hit_idx_o    = '0;
    hit_ppn_o    = '0;
    hit_asn_o    = '0;
    hit_glob_o   = 1'b0;
    hit_rd_en_o  = '0;
    hit_wr_en_o  = '0;
    hit_frd_o    = 1'b0;
    hit_fwr_o    = 1'b0;
    if (main_hit) begin
      hit_idx_o   = sel;
      hit_ppn_o   = ppn_q[sel];
      hit_asn_o   = asn_q[sel];
      hit_glob_o  = glob_q[sel];
      hit_rd_en_o = rd_q[sel];
      hit_wr_en_o = wr_q[sel];
      hit_frd_o   = frd_q[sel];
      hit_fwr_o   = fwr_q[sel];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      unique case (op)
        OP_INSERT:     vld_q[victim_q] <= 1'b1;
        OP_FLUSH_ALL:  vld_q <= '0;
        OP_FLUSH_PROC: vld_q <= vld_q & glob_q;
        OP_FLUSH_ADDR: vld_q <= vld_q & ~inv_vec;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (op == OP_INSERT) begin
      tag_q[victim_q]  <= ins_vpn_i;
      ppn_q[victim_q]  <= ins_ppn_i;
      asn_q[victim_q]  <= ins_asn_i;
      glob_q[victim_q] <= ins_glob_i;
      rd_q[victim_q]   <= ins_rd_en_i;
      wr_q[victim_q]   <= ins_wr_en_i;
      frd_q[victim_q]  <= ins_frd_i;
      fwr_q[victim_q]  <= ins_fwr_i;
    end
  end

endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 19,
  parameter int ASN_W     = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VPN_W-1:0] lk_vpn_i,
  input logic [ASN_W-1:0] lk_asn_i,
  input logic             ins_i,
  input logic [VPN_W-1:0] ins_vpn_i,
  input logic [ASN_W-1:0] ins_asn_i,
  input logic             inv_all_i,
  input logic             inv_proc_i,
  input logic             inv_addr_i,
  input logic [VPN_W-1:0] inv_vpn_i,
  input logic [ASN_W-1:0] inv_asn_i,
  input logic             hit_o,
  input logic             recent_hit_o,
  input logic             hit_glob_o,
  input logic [IDX_W-1:0] ptr_i
);

  logic any_op;
  assign any_op = ins_i || inv_all_i || inv_proc_i || inv_addr_i;

  // R4: a recent-store hit is always a real match
  a_r4_recent_is_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recent_hit_o |-> hit_o);

  // R4: an array-only hit is served from the recent store next cycle
  a_r4_promote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && hit_o && !recent_hit_o && !any_op) ##1
    ($stable(lk_vpn_i) && $stable(lk_asn_i)) |-> recent_hit_o);

  // R5: every operation empties the recent store
  a_r5_clear_recent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_op |=> !recent_hit_o);

  // R6: an inserted mapping is found in the following cycle
  a_r6_insert_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i ##1 (lk_vpn_i == $past(ins_vpn_i) && lk_asn_i == $past(ins_asn_i))
    |-> hit_o);

  // R6: the victim pointer steps by one and wraps
  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> ptr_i == (($past(ptr_i) == IDX_W'(N_ENTRIES - 1)) ? '0 : $past(ptr_i) + 1'b1));

  // R7, R10: invalidate-all empties the array and resets the pointer
  a_r7_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !ins_i) |=> (!hit_o && ptr_i == '0));

  // R8: only global slots survive a process flush
  a_r8_keep_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_proc_i && !ins_i && !inv_all_i) |=> (!hit_o || hit_glob_o));

  // R9: the flushed page and address space no longer hit
  a_r9_flush_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_addr_i && !ins_i && !inv_all_i && !inv_proc_i) ##1
    (lk_vpn_i == $past(inv_vpn_i) && lk_asn_i == $past(inv_asn_i)) |-> !hit_o);

endmodule

bind asn_tlb asn_tlb_chk #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i),
  .lk_asn_i(lk_asn_i), .ins_i(ins_i), .ins_vpn_i(ins_vpn_i), .ins_asn_i(ins_asn_i),
  .inv_all_i(inv_all_i), .inv_proc_i(inv_proc_i), .inv_addr_i(inv_addr_i),
  .inv_vpn_i(inv_vpn_i), .inv_asn_i(inv_asn_i), .hit_o(hit_o),
  .recent_hit_o(recent_hit_o), .hit_glob_o(hit_glob_o), .ptr_i(victim_q)
);

// File: tb/sim_asn_tlb.sv
`timescale 1ns/1ps
module sim_asn_tlb;

  localparam int N  = 16;
  localparam int VW = 19;
  localparam int PW = 21;
  localparam int AW = 8;
  localparam int NM = 4;
  localparam int NR = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          lk_req = 0, ins = 0, ins_glob = 0, ins_frd = 0, ins_fwr = 0;
  logic [VW-1:0] lk_vpn = 0, ins_vpn = 0, inv_vpn = 0;
  logic [AW-1:0] lk_asn = 0, ins_asn = 0, inv_asn = 0;
  logic [PW-1:0] ins_ppn = 0;
  logic [NM-1:0] ins_rd = 0, ins_wr = 0;
  logic          inv_all = 0, inv_proc = 0, inv_addr = 0;

  logic          hit, rhit, hglob, hfrd, hfwr;
  logic [IW-1:0] hidx;
  logic [PW-1:0] hppn;
  logic [AW-1:0] hasn;
  logic [NM-1:0] hrd, hwr;

  asn_tlb u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_asn_i(lk_asn),
    .ins_i(ins), .ins_vpn_i(ins_vpn), .ins_ppn_i(ins_ppn), .ins_asn_i(ins_asn),
    .ins_glob_i(ins_glob), .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
    .ins_frd_i(ins_frd), .ins_fwr_i(ins_fwr), .inv_all_i(inv_all),
    .inv_proc_i(inv_proc), .inv_addr_i(inv_addr), .inv_vpn_i(inv_vpn),
    .inv_asn_i(inv_asn), .hit_o(hit), .recent_hit_o(rhit), .hit_idx_o(hidx),
    .hit_ppn_o(hppn), .hit_asn_o(hasn), .hit_glob_o(hglob), .hit_rd_en_o(hrd),
    .hit_wr_en_o(hwr), .hit_frd_o(hfrd), .hit_fwr_o(hfwr)
  );

  // reference model
  logic          r_vld[N], r_glob[N], r_frd[N], r_fwr[N];
  logic [VW-1:0] r_tag[N];
  logic [PW-1:0] r_ppn[N];
  logic [AW-1:0] r_asn[N];
  logic [NM-1:0] r_rd[N], r_wr[N];
  int            r_ptr;
  logic          c_vld[NR];
  int            c_idx[NR];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input logic ok, input string rq, input string ctx,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h", rq, ctx, act, exp);
    end
  endtask

  function automatic logic ref_match(input int i, input logic [VW-1:0] v, input logic [AW-1:0] a);
    return r_vld[i] && r_tag[i] == v && (r_glob[i] || r_asn[i] == a);
  endfunction

  task automatic ref_look(output logic eh, output int ei, output logic er);
    eh = 0; ei = 0; er = 0;
    for (int s = 0; s < NR; s++)
      if (!er && c_vld[s] && ref_match(c_idx[s], lk_vpn, lk_asn)) begin
        er = 1; ei = c_idx[s];
      end
    for (int i = N - 1; i >= 0; i--)
      if (ref_match(i, lk_vpn, lk_asn)) begin
        eh = 1;
        if (!er) ei = i;
      end
  endtask

  task automatic ref_update(input logic eh, input int ei, input logic er);
    logic [N-1:0] kill;
    bit any;
    any = ins || inv_all || inv_proc || inv_addr;
    if (any) begin
      for (int s = 0; s < NR; s++) c_vld[s] = 0;
    end else if (lk_req && eh && !er) begin
      for (int s = NR - 1; s > 0; s--) begin
        c_vld[s] = c_vld[s-1]; c_idx[s] = c_idx[s-1];
      end
      c_vld[0] = 1; c_idx[0] = ei;
    end
    if (ins) begin
      r_vld[r_ptr] = 1; r_tag[r_ptr] = ins_vpn; r_ppn[r_ptr] = ins_ppn;
      r_asn[r_ptr] = ins_asn; r_glob[r_ptr] = ins_glob; r_rd[r_ptr] = ins_rd;
      r_wr[r_ptr] = ins_wr; r_frd[r_ptr] = ins_frd; r_fwr[r_ptr] = ins_fwr;
      r_ptr = (r_ptr == N - 1) ? 0 : r_ptr + 1;
    end else if (inv_all) begin
      for (int i = 0; i < N; i++) r_vld[i] = 0;
      r_ptr = 0;
    end else if (inv_proc) begin
      for (int i = 0; i < N; i++) if (!r_glob[i]) r_vld[i] = 0;
    end else if (inv_addr) begin
      for (int i = 0; i < N; i++) kill[i] = ref_match(i, inv_vpn, inv_asn);
      for (int i = 0; i < N; i++) if (kill[i]) r_vld[i] = 0;
    end
  endtask

  // one cycle: compare outputs, then advance model at the edge
  task automatic step(input string ctx);
    logic eh, er;
    int ei;
    logic [63:0] act, exp;
    #1;
    ref_look(eh, ei, er);
    chk(hit === eh, "R2", ctx, 64'(hit), 64'(eh));
    chk(rhit === er, "R4", ctx, 64'(rhit), 64'(er));
    act = {hidx, hppn, hasn, hglob, hrd, hwr, hfrd, hfwr};
    if (eh)
      exp = {IW'(ei), r_ppn[ei], r_asn[ei], r_glob[ei], r_rd[ei], r_wr[ei], r_frd[ei], r_fwr[ei]};
    else
      exp = '0;
    chk(act === exp, "R3", ctx, act, exp);
    @(posedge clk);
    ref_update(eh, ei, er);
    @(negedge clk);
  endtask

  task automatic idle_ops();
    ins = 0; inv_all = 0; inv_proc = 0; inv_addr = 0;
  endtask

  task automatic look(input int v, input int a, input string ctx);
    idle_ops(); lk_req = 1; lk_vpn = VW'(v); lk_asn = AW'(a);
    step(ctx);
  endtask

  task automatic put(input int v, input int a, input logic g, input int p, input string ctx);
    idle_ops(); lk_req = 0; ins = 1;
    ins_vpn = VW'(v); ins_asn = AW'(a); ins_glob = g; ins_ppn = PW'(p);
    ins_rd = NM'($urandom); ins_wr = NM'($urandom);
    ins_frd = 1'($urandom); ins_fwr = 1'($urandom);
    step(ctx);
    ins = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) r_vld[i] = 0;
    for (int s = 0; s < NR; s++) begin c_vld[s] = 0; c_idx[s] = 0; end
    r_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    look(3, 1, "R1 reset");
    look(0, 0, "R1 reset");

    // R6: fill in pointer order, page i at slot i
    for (int i = 0; i < N; i++) put(i, 1, (i % 4) == 0, 100 + i, "R6 fill");
    for (int i = 0; i < N; i++) look(i, 1, "R6 order");
    look(4, 2, "R2 global any asn");
    look(5, 2, "R2 asn mismatch");
    // R6: wrap overwrites slot 0
    put(20, 1, 0, 200, "R6 wrap");
    look(0, 1, "R6 overwritten");
    look(20, 1, "R6 wrap idx0");
    // R3: duplicate page, lower slot wins
    put(8, 5, 1, 300, "R3 dup");
    look(8, 1, "R3 lowest idx");
    put(7, 2, 0, 301, "R3 dup asn");
    look(7, 2, "R3 asn dup");
    look(7, 1, "R3 other asn");
    // R4: promotion and aging
    look(9, 1, "R4 first");
    look(9, 1, "R4 second");
    look(10, 1, "R4 fill");
    look(11, 1, "R4 fill");
    look(12, 1, "R4 fill");
    look(9, 1, "R4 aged out");
    lk_req = 0; lk_vpn = 13; step("R4 no req no promote");
    look(13, 1, "R4 after unreq");
    // R5: insert empties recent store
    look(13, 1, "R5 cached");
    put(30, 3, 0, 400, "R5 insert");
    look(13, 1, "R5 cleared");
    // R8: process flush keeps globals
    idle_ops(); lk_req = 0; inv_proc = 1; step("R8 flush");
    for (int i = 0; i < 24; i++) look(i, 1, "R8 survivors");
    // R9: address flush
    put(40, 6, 0, 500, "R9 setup");
    put(40, 7, 0, 501, "R9 setup");
    put(41, 6, 1, 502, "R9 setup");
    idle_ops(); inv_addr = 1; inv_vpn = 40; inv_asn = 6; step("R9 flush");
    look(40, 6, "R9 gone");
    look(40, 7, "R9 other asn kept");
    idle_ops(); inv_addr = 1; inv_vpn = 41; inv_asn = 9; step("R9 global flush");
    look(41, 6, "R9 global gone");
    // R10: insert beats invalidate-all
    idle_ops(); ins = 1; inv_all = 1; ins_vpn = 50; ins_asn = 1; ins_ppn = 600; ins_glob = 0;
    step("R10 ins+all");
    look(50, 1, "R10 insert won");
    look(40, 7, "R10 no flush");
    idle_ops(); inv_all = 1; inv_proc = 1; step("R10 all+proc");
    look(4, 1, "R10 all won");
    // R7: pointer back to zero
    put(60, 2, 0, 700, "R7 reinsert");
    look(60, 2, "R7 idx0");

    // random traffic over a small page space
    for (int k = 0; k < 3000; k++) begin
      int r;
      idle_ops();
      r = int'($urandom_range(0, 99));
      lk_req = 1'($urandom_range(0, 4) != 0);
      lk_vpn = VW'($urandom_range(0, 9));
      lk_asn = AW'($urandom_range(0, 3));
      ins_vpn = VW'($urandom_range(0, 9)); ins_asn = AW'($urandom_range(0, 3));
      ins_glob = 1'($urandom_range(0, 3) == 0); ins_ppn = PW'($urandom);
      ins_rd = NM'($urandom); ins_wr = NM'($urandom);
      ins_frd = 1'($urandom); ins_fwr = 1'($urandom);
      inv_vpn = VW'($urandom_range(0, 9)); inv_asn = AW'($urandom_range(0, 3));
      if (r < 15) ins = 1;
      else if (r < 19) inv_addr = 1;
      else if (r < 21) inv_proc = 1;
      else if (r < 22) inv_all = 1;
      else if (r < 25) begin
        ins = 1'($urandom); inv_all = 1'($urandom);
        inv_proc = 1'($urandom); inv_addr = 1;
      end
      step("rnd R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule